// File: doc/BRIEF.md
# List-Mode Event Record Formatter

This block turns one detector event into a stream of 32-bit words for a list-mode readout path. A caller presents an event timestamp, a per-event channel hit mask and a configured trace length, then raises `start`. The formatter latches these values and raises `busy`. It then emits a fixed three-word event header. After that it emits one block for each hit channel, from the lowest channel number to the highest. Each block is a nine-word channel header followed by the channel's trace, with two samples packed into every word. Output moves on a valid/ready handshake, and `o_last` marks the final word of the record.

Per-channel values are not supplied as wide buses. The formatter drives a lookup address made of `rd_ch` and `rd_word`. The surrounding logic answers combinationally with that channel's trigger time, energy and three filter sums, and with the two trace samples of the addressed word. These lookup inputs must stay constant while the address is unchanged.

The sequencer has four states. ST_IDLE moves to ST_EVHDR when `start` is seen. ST_EVHDR moves to ST_CHHDR after its third word, or to ST_IDLE if no channel was hit. ST_CHHDR moves to ST_TRACE after its ninth word if the trace is not empty. Otherwise it moves straight to ST_CHHDR for the next hit channel, or to ST_IDLE. ST_TRACE moves to ST_CHHDR for the next hit channel or to ST_IDLE after its last trace word. A word advances a state or counter only when it is handed over.

Top module: `fmt_event_rec`

## Requirements
- R1: After reset `busy`, `o_valid` and `len_err` are 0.
- R2: `start` is taken only while `busy` is 0. `busy` rises on the following cycle and falls on the cycle after the final word is accepted. A `start` seen while `busy` is 1 is ignored, including its mask, time and length.
- R3: The event header holds three words in this order. Word 0 is the hit mask, zero-extended, with bit n standing for channel n. Word 1 is timestamp bits [47:32], zero-extended. Word 2 is timestamp bits [31:0].
- R4: A channel block follows the event header only for each set mask bit, in increasing channel order.
- R5: Each channel header is nine words in this order: word count, trigger time, energy, trailing sum, leading sum, gap sum, and three words of zero.
- R6: The word count equals 9 plus the number of trace words, and the trace word count is the configured sample count divided by two.
- R7: Trace word w carries sample 2w in bits [15:0] and sample 2w+1 in bits [31:16]. `rd_word` equals w while that word is offered, and `rd_ch` names the channel of the current block.
- R8: An odd configured length is rounded down to the even count below it. Accepting such a `start` sets `len_err`, which stays 1 until reset.
- R9: While `o_valid` is 1 and `o_ready` is 0, `o_valid`, `o_data` and `o_last` keep their values into the next cycle.
- R10: `o_last` is 1 on the final word of the record only. With an empty mask, that final word is timestamp word 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request to format a new event |
| busy | output | 1 | Event in progress |
| ev_mask | input | 16 | Channel hit mask, bit n = channel n |
| ev_time | input | 48 | Event timestamp |
| trace_len | input | 11 | Trace samples per channel |
| len_err | output | 1 | Sticky odd-length flag |
| rd_ch | output | 4 | Lookup channel index |
| rd_word | output | 10 | Lookup trace word index |
| ch_trig | input | 32 | Trigger time of `rd_ch` |
| ch_energy | input | 32 | Energy of `rd_ch` |
| ch_tsum | input | 32 | Trailing filter sum of `rd_ch` |
| ch_lsum | input | 32 | Leading filter sum of `rd_ch` |
| ch_gsum | input | 32 | Gap filter sum of `rd_ch` |
| smp_early | input | 16 | Sample 2*`rd_word` of `rd_ch` |
| smp_late | input | 16 | Sample 2*`rd_word`+1 of `rd_ch` |
| o_valid | output | 1 | Output word valid |
| o_ready | input | 1 | Consumer ready |
| o_data | output | 32 | Output word |
| o_last | output | 1 | Final word of the record |

## Verification
Two moments coincide in this design. In one, a stall lands on a block boundary: the last channel-header or trace word of one channel is held by backpressure while the scan has already chosen the next channel and decided the value of `o_last`. The bench provokes this with three ready patterns: always ready, two of three cycles, and two of five cycles. It judges every handed-over word and flag against an expected stream computed from the requirements, and it checks that each stalled word is held unchanged. In the other, `start` is raised mid-record together with an inverted mask, an inverted time and an odd length. The bench judges that case by the stream staying exact and `len_err` staying 0.

// File: rtl/fmt_rec_pkg.sv
package fmt_rec_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_EVHDR,
        ST_CHHDR,
        ST_TRACE
    } fmt_state_e;

    localparam int EVHDR_WORDS = 3;
    localparam int CHHDR_WORDS = 9;
    localparam int WORD_W      = 32;
endpackage

// File: rtl/fmt_hit_scan.sv
module fmt_hit_scan #(
    parameter int NCH  = 16,
    parameter int CH_W = $clog2(NCH)
) (
    input  logic [NCH-1:0]  mask,
    output logic            found,
    output logic [CH_W-1:0] idx
);
    // lowest set bit wins: scan from the top so the last hit assigned is the lowest
    always_comb begin
        found = |mask;
        idx   = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (mask[i]) idx = CH_W'(i);
        end
    end
endmodule

// File: rtl/fmt_sample_pack.sv
module fmt_sample_pack #(
    parameter int SMP_W = 16
) (
    input  logic [SMP_W-1:0]   early,
    input  logic [SMP_W-1:0]   late,
    output logic [2*SMP_W-1:0] word
);
    // older sample sits in the low half
    assign word = {late, early};
endmodule

// File: rtl/fmt_seq.sv
module fmt_seq
    import fmt_rec_pkg::*;
#(
    parameter int NCH    = 16,
    parameter int CH_W   = $clog2(NCH),
    parameter int TS_W   = 48,
    parameter int LEN_W  = 11,
    parameter int WORD_W = 32,
    localparam int WRD_W = LEN_W - 1,
    localparam int HI_W  = TS_W - 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output logic              busy,
    input  logic [NCH-1:0]    ev_mask,
    input  logic [TS_W-1:0]   ev_time,
    input  logic [LEN_W-1:0]  trace_len,
    output logic              len_err,
    output logic [NCH-1:0]    pending,
    input  logic              nxt_found,
    input  logic [CH_W-1:0]   nxt_idx,
    output logic [CH_W-1:0]   rd_ch,
    output logic [WRD_W-1:0]  rd_word,
    input  logic [WORD_W-1:0] ch_trig,
    input  logic [WORD_W-1:0] ch_energy,
    input  logic [WORD_W-1:0] ch_tsum,
    input  logic [WORD_W-1:0] ch_lsum,
    input  logic [WORD_W-1:0] ch_gsum,
    input  logic [WORD_W-1:0] trc_word,
    output logic              o_valid,
    input  logic              o_ready,
    output logic [WORD_W-1:0] o_data,
    output logic              o_last
);
    fmt_state_e        state, state_d;
    logic [3:0]        sub_cnt;
    logic [WRD_W-1:0]  wrd_cnt;
    logic [WRD_W-1:0]  n_words;
    logic [NCH-1:0]    mask_q;
    logic [TS_W-1:0]   ts_q;
    logic              fire;
    logic              evhdr_end;
    logic              chhdr_end;
    logic              trace_end;
    logic              chan_done;
    logic              go_ch;
    logic              accept;

    assign fire      = o_valid && o_ready;
    assign accept    = (state == ST_IDLE) && start;
    assign evhdr_end = (state == ST_EVHDR) && (sub_cnt == 4'(EVHDR_WORDS - 1));
    assign chhdr_end = (state == ST_CHHDR) && (sub_cnt == 4'(CHHDR_WORDS - 1));
    assign trace_end = (state == ST_TRACE) && (wrd_cnt == n_words - WRD_W'(1));
    assign chan_done = (chhdr_end && (n_words == '0)) || trace_end;

    // next-state decision
    always_comb begin
        state_d = state;
        go_ch   = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (start) state_d = ST_EVHDR;
            end
            ST_EVHDR: begin
                if (fire && evhdr_end) begin
                    state_d = nxt_found ? ST_CHHDR : ST_IDLE;
                    go_ch   = nxt_found;
                end
            end
            ST_CHHDR: begin
                if (fire && chhdr_end) begin
                    if (n_words != '0) begin
                        state_d = ST_TRACE;
                    end else begin
                        state_d = nxt_found ? ST_CHHDR : ST_IDLE;
                        go_ch   = nxt_found;
                    end
                end
            end
            ST_TRACE: begin
                if (fire && trace_end) begin
                    state_d = nxt_found ? ST_CHHDR : ST_IDLE;
                    go_ch   = nxt_found;
                end
            end
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_d;
    end

    // counters, latched event data, channel walk
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sub_cnt <= '0;
            wrd_cnt <= '0;
            n_words <= '0;
            mask_q  <= '0;
            ts_q    <= '0;
            pending <= '0;
            rd_ch   <= '0;
            len_err <= 1'b0;
        end else begin
            if (accept) begin
                mask_q  <= ev_mask;
                ts_q    <= ev_time;
                pending <= ev_mask;
                n_words <= trace_len[LEN_W-1:1];
                sub_cnt <= '0;
                wrd_cnt <= '0;
                if (trace_len[0]) len_err <= 1'b1;
            end else if (go_ch) begin
                rd_ch   <= nxt_idx;
                pending <= pending & ~(NCH'(1) << nxt_idx);
                sub_cnt <= '0;
                wrd_cnt <= '0;
            end else if (fire) begin
                if (state == ST_TRACE) wrd_cnt <= wrd_cnt + WRD_W'(1);
                else                   sub_cnt <= sub_cnt + 4'd1;
            end
        end
    end

    assign rd_word = wrd_cnt;
    assign busy    = (state != ST_IDLE);
    assign o_valid = busy;

    // output word and end-of-record flag
    always_comb begin
        o_data = '0;
        o_last = 1'b0;
        unique case (state)
            ST_IDLE: begin
                o_data = '0;
            end
            ST_EVHDR: begin
                o_last = evhdr_end && !nxt_found;
                unique case (sub_cnt)
                    4'd0:    o_data = WORD_W'(mask_q);
                    4'd1:    o_data = WORD_W'(ts_q[TS_W-1:32]);
                    default: o_data = ts_q[31:0];
                endcase
            end
            ST_CHHDR: begin
                o_last = chan_done && !nxt_found;
                unique case (sub_cnt)
                    4'd0:    o_data = WORD_W'(CHHDR_WORDS) + WORD_W'(n_words);
                    4'd1:    o_data = ch_trig;
                    4'd2:    o_data = ch_energy;
                    4'd3:    o_data = ch_tsum;
                    4'd4:    o_data = ch_lsum;
                    4'd5:    o_data = ch_gsum;
                    default: o_data = '0;
                endcase
            end
            ST_TRACE: begin
                o_last = trace_end && !nxt_found;
                o_data = trc_word;
            end
        endcase
    end
endmodule

// File: rtl/fmt_event_rec.sv
module fmt_event_rec #(
    parameter int NCH    = 16,
    parameter int TS_W   = 48,
    parameter int LEN_W  = 11,
    parameter int SMP_W  = 16,
    localparam int CH_W   = $clog2(NCH),
    localparam int WORD_W = 2 * SMP_W,
    localparam int WRD_W  = LEN_W - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output logic              busy,
    input  logic [NCH-1:0]    ev_mask,
    input  logic [TS_W-1:0]   ev_time,
    input  logic [LEN_W-1:0]  trace_len,
    output logic              len_err,
    output logic [CH_W-1:0]   rd_ch,
    output logic [WRD_W-1:0]  rd_word,
    input  logic [WORD_W-1:0] ch_trig,
    input  logic [WORD_W-1:0] ch_energy,
    input  logic [WORD_W-1:0] ch_tsum,
    input  logic [WORD_W-1:0] ch_lsum,
    input  logic [WORD_W-1:0] ch_gsum,
    input  logic [SMP_W-1:0]  smp_early,
    input  logic [SMP_W-1:0]  smp_late,
    output logic              o_valid,
    input  logic              o_ready,
    output logic [WORD_W-1:0] o_data,
    output logic              o_last
);
    logic [NCH-1:0]    pending;
    logic              nxt_found;
    logic [CH_W-1:0]   nxt_idx;
    logic [WORD_W-1:0] trc_word;

    fmt_hit_scan #(.NCH(NCH), .CH_W(CH_W)) scan_i (
        .mask  (pending),
        .found (nxt_found),
        .idx   (nxt_idx)
    );

    fmt_sample_pack #(.SMP_W(SMP_W)) pack_i (
        .early (smp_early),
        .late  (smp_late),
        .word  (trc_word)
    );

    fmt_seq #(
        .NCH    (NCH),
        .CH_W   (CH_W),
        .TS_W   (TS_W),
        .LEN_W  (LEN_W),
        .WORD_W (WORD_W)
    ) seq_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .busy      (busy),
        .ev_mask   (ev_mask),
        .ev_time   (ev_time),
        .trace_len (trace_len),
        .len_err   (len_err),
        .pending   (pending),
        .nxt_found (nxt_found),
        .nxt_idx   (nxt_idx),
        .rd_ch     (rd_ch),
        .rd_word   (rd_word),
        .ch_trig   (ch_trig),
        .ch_energy (ch_energy),
        .ch_tsum   (ch_tsum),
        .ch_lsum   (ch_lsum),
        .ch_gsum   (ch_gsum),
        .trc_word  (trc_word),
        .o_valid   (o_valid),
        .o_ready   (o_ready),
        .o_data    (o_data),
        .o_last    (o_last)
    );
endmodule

// File: rtl/fmt_event_rec_chk.sv
module fmt_event_rec_chk #(
    parameter int WORD_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              busy,
    input logic              len_odd,
    input logic              len_err,
    input logic              o_valid,
    input logic              o_ready,
    input logic [WORD_W-1:0] o_data,
    input logic              o_last
);
    // R9
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (o_valid && !o_ready) |=> (o_valid && $stable(o_data) && $stable(o_last)));

    // R2
    start_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    // R2
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !(o_valid && o_ready && o_last)) |=> busy);

    // R10
    last_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (o_valid && o_ready && o_last) |=> !busy);

    // R8
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        len_err |=> len_err);

    // R8
    err_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && len_odd) |=> len_err);
endmodule

bind fmt_event_rec fmt_event_rec_chk chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .busy    (busy),
    .len_odd (trace_len[0]),
    .len_err (len_err),
    .o_valid (o_valid),
    .o_ready (o_ready),
    .o_data  (o_data),
    .o_last  (o_last)
);

// File: tb/fmt_event_rec_tb_top.sv
module fmt_event_rec_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        start;
    logic        busy;
    logic [15:0] ev_mask;
    logic [47:0] ev_time;
    logic [10:0] trace_len;
    logic        len_err;
    logic [3:0]  rd_ch;
    logic [9:0]  rd_word;
    logic [31:0] ch_trig, ch_energy, ch_tsum, ch_lsum, ch_gsum;
    logic [15:0] smp_early, smp_late;
    logic        o_valid;
    logic        o_ready;
    logic [31:0] o_data;
    logic        o_last;

    int n_chk = 0;
    int n_err = 0;
    int cyc_total = 0;

    always #4 clk = ~clk;

    fmt_event_rec dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .busy(busy),
        .ev_mask(ev_mask), .ev_time(ev_time), .trace_len(trace_len),
        .len_err(len_err), .rd_ch(rd_ch), .rd_word(rd_word),
        .ch_trig(ch_trig), .ch_energy(ch_energy), .ch_tsum(ch_tsum),
        .ch_lsum(ch_lsum), .ch_gsum(ch_gsum),
        .smp_early(smp_early), .smp_late(smp_late),
        .o_valid(o_valid), .o_ready(o_ready), .o_data(o_data), .o_last(o_last)
    );

    function automatic logic [31:0] field_of(input int c, input int k);
        return {4'(k), 20'h0, 8'(c)};
    endfunction

    function automatic logic [15:0] smp_of(input int c, input int s);
        return {4'(c), 12'(s)};
    endfunction

    // lookup model answering the formatter's address
    always_comb begin
        ch_trig   = field_of(int'(rd_ch), 1);
        ch_energy = field_of(int'(rd_ch), 2);
        ch_tsum   = field_of(int'(rd_ch), 3);
        ch_lsum   = field_of(int'(rd_ch), 4);
        ch_gsum   = field_of(int'(rd_ch), 5);
        smp_early = smp_of(int'(rd_ch), 2 * int'(rd_word));
        smp_late  = smp_of(int'(rd_ch), 2 * int'(rd_word) + 1);
    end

    task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc_total++;
        if (cyc_total > 150000) begin
            n_err++;
            $display("FAIL watchdog actual=expired expected=done");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    // expected stream: bit 32 = last flag
    logic [32:0] exp_q  [0:4095];
    string       exp_rq [0:4095];
    int          exp_n;

    task automatic push(input logic [31:0] d, input string rq);
        exp_q[exp_n]  = {1'b0, d};
        exp_rq[exp_n] = rq;
        exp_n++;
    endtask

    task automatic build(input logic [15:0] m, input logic [47:0] t, input int len);
        int nw;
        exp_n = 0;
        nw = len / 2;
        push({16'h0, m}, "R3");
        push({16'h0, t[47:32]}, "R3");
        push(t[31:0], "R3");
        for (int c = 0; c < 16; c++) begin
            if (m[c]) begin
                push(32'(9 + nw), "R6");
                for (int k = 1; k <= 5; k++) push(field_of(c, k), "R5");
                for (int k = 0; k < 3; k++) push(32'h0, "R5");
                for (int w = 0; w < nw; w++)
                    push({smp_of(c, 2 * w + 1), smp_of(c, 2 * w)}, "R7");
            end
        end
        exp_q[exp_n-1][32] = 1'b1;
    endtask

    task automatic run_event(input logic [15:0] m, input logic [47:0] t, input int len,
                             input int mode, input bit inj);
        int          idx = 0;
        int          cyc = 0;
        bit          rdy;
        bit          stall_prev = 0;
        logic [31:0] prev_d = '0;
        logic        prev_l = 1'b0;
        logic        err_before;
        build(m, t, len);
        @(negedge clk);
        err_before = len_err;
        ev_mask = m; ev_time = t; trace_len = 11'(len); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R2 busy after start", 64'(busy), 64'd1);
        while (idx < exp_n && cyc < 20000) begin
            if (cyc > 0) @(negedge clk);
            if (inj && cyc == 4) begin
                start = 1'b1; ev_mask = ~m; ev_time = ~t; trace_len = 11'd3;
            end else if (inj && cyc == 5) begin
                start = 1'b0;
            end
            unique case (mode)
                1:       rdy = (cyc % 3) != 0;
                2:       rdy = (cyc % 5) < 2;
                default: rdy = 1'b1;
            endcase
            o_ready = rdy;
            if (stall_prev)
                chk(o_valid && o_data == prev_d && o_last == prev_l, "R9 hold under stall",
                    {31'h0, o_last, o_data}, {31'h0, prev_l, prev_d});
            if (o_valid && rdy) begin
                chk({o_last, o_data} == exp_q[idx], $sformatf("%s/R4/R10 word %0d", exp_rq[idx], idx),
                    64'({o_last, o_data}), 64'(exp_q[idx]));
                idx++;
            end
            stall_prev = o_valid && !rdy;
            prev_d = o_data;
            prev_l = o_last;
            cyc++;
        end
        chk(idx == exp_n, "R10 record complete", 64'(idx), 64'(exp_n));
        @(negedge clk);
        o_ready = 1'b1;
        chk(!busy && !o_valid, "R2 idle after last", {62'h0, busy, o_valid}, 64'd0);
        if (inj) chk(len_err == err_before, "R2 R8 ignored start leaves len_err",
                     64'(len_err), 64'(err_before));
    endtask

    localparam int NV = 7;
    localparam logic [15:0] V_MASK [NV] = '{16'h0001, 16'h0000, 16'h8000, 16'hA5A5,
                                             16'hFFFF, 16'h0102, 16'h4001};
    localparam logic [47:0] V_TS   [NV] = '{48'h1234_89AB_CDEF, 48'hFFFF_0000_0001,
                                             48'h0000_FFFF_FFFF, 48'h0BAD_F00D_0001,
                                             48'h7777_0000_1111, 48'h0001_0002_0003,
                                             48'h0005_0006_0007};
    localparam int          V_LEN  [NV] = '{4, 8, 0, 6, 2, 7, 10};
    localparam int          V_MODE [NV] = '{0, 1, 2, 1, 2, 1, 0};
    localparam logic        V_ERR  [NV] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1};

    initial begin
        rst_n = 1'b0; start = 1'b0; ev_mask = '0; ev_time = '0;
        trace_len = '0; o_ready = 1'b1;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(!busy && !o_valid && !len_err, "R1 reset state",
            {61'h0, busy, o_valid, len_err}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !o_valid, "R1 idle after reset", {62'h0, busy, o_valid}, 64'd0);

        for (int v = 0; v < NV; v++) begin
            run_event(V_MASK[v], V_TS[v], V_LEN[v], V_MODE[v], 1'b0);
            chk(len_err == V_ERR[v], "R8 len_err after event", 64'(len_err), 64'(V_ERR[v]));
        end

        // ignored start while busy, after a reset clears the sticky flag
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk(!len_err && !busy, "R1 R8 reset clears len_err", {62'h0, len_err, busy}, 64'd0);
        rst_n = 1'b1;
        run_event(16'h0011, 48'hABCD_1234_5678, 4, 1, 1'b1);

        // channel 15 only with an odd length of one sample: count 9, flag set
        run_event(16'h8000, 48'h0, 1, 0, 1'b0);
        chk(len_err == 1'b1, "R8 odd length one", 64'(len_err), 64'd1);

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule